// File: doc/BRIEF.md
# Page-Buffered Flash Write Sequencer

This block is the control logic inside a byte-wide nonvolatile memory that is programmed one page at a time. The storage array is modelled as an on-chip RAM. The host uses three active-low strobes: chip select, output enable and write enable. A read puts array data on the data bus. A write cycle loads one byte into a 128-byte page buffer.

No command starts programming. Once the host stops loading bytes for a set number of clock cycles, the sequencer enters a timed internal programming phase. In that phase it copies the whole buffer into one array page. Any buffer position that was not loaded in the current load phase is written as FFh.

While programming runs, reads return status rather than data. Bit 7 holds the complement of bit 7 of the last loaded byte. Bit 6 changes value on every read access. A host can poll either bit to find out when the page has been committed. The load timeout and the programming time are parameters in clock cycles. A busy output is also brought out.

Top module: `pgflash_seq`

## Requirements
- R1: `dq_oe` is 1 exactly one clock after `ce_n` and `oe_n` are both sampled low, and 0 one clock after either is sampled high. `dq_out` shows the array byte at `addr` two clocks after the address is applied.
- R2: A byte load happens only while `ce_n` and `we_n` are both low and `oe_n` is high. The address is taken in the first clock of that condition. The data is taken in the clock where the condition ends. If `oe_n` is low, no byte is loaded.
- R3: The page buffer holds 128 bytes. `addr[6:0]` selects the byte offset and the bits above select the page. The array keeps the low `ARR_PAGE_W` page bits.
- R4: Loading the same offset again in one load phase replaces the buffered value. The last value written is the one programmed.
- R5: The whole buffer is programmed into the page of the last byte loaded.
- R6: While each new write cycle starts fewer than `LOAD_TO_CYC` clocks after the previous load, `busy` stays 0. There is no limit on the number of loads.
- R7: `busy` rises `LOAD_TO_CYC` clocks after the last load, give or take two clocks. It then stays 1 for exactly `PROG_CYC` clocks and cannot be interrupted.
- R8: Every offset not loaded in the current load phase is programmed as FFh.
- R9: A read while `busy` is 1 returns bit 7 equal to the complement of bit 7 of the last loaded byte.
- R10: While `busy` is 1, bit 6 changes between successive read accesses. After completion, bit 6 and bit 7 give the true array data.
- R11: Write cycles while `busy` is 1 are ignored. They change neither the buffer nor the status bits, and they start no new load phase.
- R12: After reset, `busy` and `dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in bits 6:0 |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data or programming status |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| busy | output | 1 | Internal programming in progress |

## Verification
The assertions check, on every clock, the following:
- the load timeout counter stays in range;
- the capture address stays stable through a write cycle;
- a fresh load phase starts with exactly one valid buffer byte;
- busy falls only after the full programming count;
- the status bits stay frozen while programming runs;
- the DQ7 complement appears on status reads.

Only the bench's scenarios can show the rest:
- array contents after a commit, including FFh fill, overwrites and page selection by the last byte;
- the DQ6 toggle sequence across separate reads;
- write cycles that are rejected because `oe_n` is low or because the block is busy.

// File: rtl/pgflash_pkg.sv
package pgflash_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;
endpackage

// File: rtl/pgflash_strobe.sv
// Decodes the strobe pins into write-cycle and read-access events.
module pgflash_strobe #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              load_stb,
  output logic [ADDR_W-1:0] load_addr,
  output logic [7:0]        load_data,
  output logic              wr_act,
  output logic              rd_act,
  output logic              rd_start
);
  logic              wr_q, rd_q;
  logic [ADDR_W-1:0] addr_l;

  assign wr_act = ~ce_n & ~we_n & oe_n;
  assign rd_act = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_l <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // later falling edge of the two strobes: first cycle of the write condition
      if (wr_act && !wr_q) addr_l <= addr;
    end
  end

  // first rising edge of the two strobes: write condition just ended
  assign load_stb  = wr_q & ~wr_act;
  assign load_addr = addr_l;
  assign load_data = din;
  assign rd_start  = rd_act & ~rd_q;

  // R2: captured address held for the whole write cycle
  a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
    (wr_q && wr_act) |=> $stable(addr_l));
endmodule

// File: rtl/pgflash_pagebuf.sv
// Page buffer: data RAM plus a per-byte loaded mask; unloaded reads give FFh.
module pgflash_pagebuf #(
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             clr,
  input  logic [OFF_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [OFF_W-1:0] raddr,
  output logic [7:0]       rdata
);
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded, loaded_nxt;
  logic [7:0]            rd_q;
  logic                  vld_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_comb begin
    loaded_nxt = clr ? '0 : loaded;
    if (we) loaded_nxt[waddr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
      vld_q  <= 1'b0;
    end else begin
      loaded <= loaded_nxt;
      vld_q  <= loaded[raddr];
    end
  end

  assign rdata = vld_q ? rd_q : 8'hFF;

  // R8: a new load phase leaves exactly one byte marked loaded
  a_r8_fresh_phase: assert property (@(posedge clk) disable iff (rst)
    (clr && we) |=> ($countones(loaded) == 1));
endmodule

// File: rtl/pgflash_ctrl.sv
// Phase sequencer: load timeout, programming timer and buffer-to-array copy.
module pgflash_ctrl
  import pgflash_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int OFF_W       = 7,
  parameter int ARR_PAGE_W  = 3,
  parameter int LOAD_TO_CYC = 25000,
  parameter int PROG_CYC    = 625000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_stb,
  input  logic [ADDR_W-1:0]           load_addr,
  input  logic                        wr_act,
  output logic                        buf_we,
  output logic                        buf_clr,
  output logic [OFF_W-1:0]            buf_raddr,
  output logic                        arr_we,
  output logic [ARR_PAGE_W+OFF_W-1:0] arr_waddr,
  output logic                        busy,
  output logic                        last_d7_n,
  input  logic [7:0]                  load_data
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int TO_W       = $clog2(LOAD_TO_CYC + 1);
  localparam int PG_W       = $clog2(PROG_CYC + 1);
  // PROG_CYC must exceed PAGE_BYTES + 1 so the copy completes inside the phase.

  phase_t                phase;
  logic [TO_W-1:0]       to_cnt;
  logic [PG_W-1:0]       pg_cnt;
  logic [ARR_PAGE_W-1:0] last_page;
  logic                  last_d7;
  logic                  cp_vld, cp_vld_q;
  logic [OFF_W-1:0]      cp_idx_q;

  assign buf_we  = load_stb && (phase != PH_PROG);
  assign buf_clr = buf_we && (phase == PH_IDLE);
  assign busy    = (phase == PH_PROG);
  assign last_d7_n = ~last_d7;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      to_cnt    <= '0;
      pg_cnt    <= '0;
      last_page <= '0;
      last_d7   <= 1'b0;
    end else begin
      if (buf_we) begin
        last_page <= load_addr[OFF_W +: ARR_PAGE_W];
        last_d7   <= load_data[7];
      end
      case (phase)
        PH_IDLE: begin
          to_cnt <= '0;
          if (buf_we) phase <= PH_LOAD;
        end
        PH_LOAD: begin
          if (buf_we || wr_act) begin
            to_cnt <= '0;
          end else if (int'(to_cnt) == LOAD_TO_CYC - 1) begin
            phase  <= PH_PROG;
            pg_cnt <= '0;
            to_cnt <= '0;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (int'(pg_cnt) == PROG_CYC - 1) phase <= PH_IDLE;
          else                              pg_cnt <= pg_cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // copy engine: one buffer byte per clock during the first PAGE_BYTES clocks
  assign cp_vld    = busy && (int'(pg_cnt) < PAGE_BYTES);
  assign buf_raddr = pg_cnt[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_vld_q <= 1'b0;
      cp_idx_q <= '0;
    end else begin
      cp_vld_q <= cp_vld;
      cp_idx_q <= pg_cnt[OFF_W-1:0];
    end
  end

  assign arr_we    = cp_vld_q;
  assign arr_waddr = {last_page, cp_idx_q};

  // R6: timeout counter never passes its window
  a_r6_to_bound: assert property (@(posedge clk) disable iff (rst)
    int'(to_cnt) < LOAD_TO_CYC);
  // R7: programming ends only after the full count
  a_r7_prog_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (int'($past(pg_cnt)) == PROG_CYC - 1));
  // R11: status state frozen during programming
  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(last_page) && $stable(last_d7)));
endmodule

// File: rtl/pgflash_array.sv
// Simple dual-port RAM standing in for the cell array.
module pgflash_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgflash_seq.sv
module pgflash_seq #(
  parameter int ADDR_W      = 17,
  parameter int OFF_W       = 7,
  parameter int ARR_PAGE_W  = 3,
  parameter int LOAD_TO_CYC = 25000,
  parameter int PROG_CYC    = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              busy
);
  localparam int AW = ARR_PAGE_W + OFF_W;

  logic              load_stb, wr_act, rd_act, rd_start;
  logic [ADDR_W-1:0] load_addr;
  logic [7:0]        load_data;
  logic              buf_we, buf_clr, arr_we, last_d7_n;
  logic [OFF_W-1:0]  buf_raddr;
  logic [AW-1:0]     arr_waddr;
  logic [7:0]        buf_rdata, arr_rdata;
  logic              dq6_tog;

  pgflash_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk, .rst, .ce_n, .oe_n, .we_n, .addr, .din,
    .load_stb, .load_addr, .load_data, .wr_act, .rd_act, .rd_start
  );

  pgflash_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ARR_PAGE_W(ARR_PAGE_W),
    .LOAD_TO_CYC(LOAD_TO_CYC), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk, .rst, .load_stb, .load_addr, .wr_act,
    .buf_we, .buf_clr, .buf_raddr, .arr_we, .arr_waddr,
    .busy, .last_d7_n, .load_data
  );

  pgflash_pagebuf #(.OFF_W(OFF_W)) u_buf (
    .clk, .rst, .we(buf_we), .clr(buf_clr),
    .waddr(load_addr[OFF_W-1:0]), .wdata(load_data),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  pgflash_array #(.AW(AW)) u_arr (
    .clk, .we(arr_we), .waddr(arr_waddr), .wdata(buf_rdata),
    .raddr(addr[AW-1:0]), .rdata(arr_rdata)
  );

  // registered read path with status substitution while programming
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe   <= 1'b0;
      dq_out  <= 8'h00;
      dq6_tog <= 1'b0;
    end else begin
      dq_oe <= rd_act;
      if (rd_start && busy) dq6_tog <= ~dq6_tog;
      dq_out <= busy ? {last_d7_n, dq6_tog, arr_rdata[5:0]} : arr_rdata;
    end
  end

  // R11: no buffer write reaches the page buffer while programming
  a_r11_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !buf_we);
  // R9: status reads show the complemented last bit 7
  a_r9_dq7_status: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(rd_act)) |-> (dq_out[7] == $past(last_d7_n)));
endmodule

// File: tb/tb_pgflash_seq.sv
module tb_pgflash_seq;
  localparam int ADDR_W = 17;
  localparam int TO     = 20;
  localparam int PROG   = 200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        din = 8'h00;
  logic [7:0]        dq_out;
  logic              dq_oe, busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pgflash_seq #(
    .ADDR_W(ADDR_W), .OFF_W(7), .ARR_PAGE_W(3),
    .LOAD_TO_CYC(TO), .PROG_CYC(PROG)
  ) dut (.*);

  // {offset[6:0], data[7:0]}; offset 5 loaded twice, last entry bit7 = 1
  localparam int NV = 8;
  localparam logic [14:0] LOADS [NV] = '{
    {7'd0,   8'h12}, {7'd5,   8'h34}, {7'd127, 8'h7E}, {7'd64,  8'h00},
    {7'd5,   8'hC9}, {7'd1,   8'hA5}, {7'd63,  8'h5A}, {7'd9,   8'h8F}
  };

  logic [7:0] exp_pg [128];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // write-enable controlled load; address disturbed after capture, data late
  task automatic wr_we(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = 8'hEE; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    tick(1);
    addr = ~a;
    tick(1);
    din = d;
    tick(1);
    we_n = 1'b1;
    tick(1);
    ce_n = 1'b1;
  endtask

  // chip-select controlled load
  task automatic wr_ce(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0; oe_n = 1'b1;
    tick(1);
    ce_n = 1'b0;
    tick(2);
    ce_n = 1'b1;
    tick(1);
    we_n = 1'b1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    tick(3);
    d = dq_out; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    tick(1);
  endtask

  task automatic wait_busy(input logic lvl, output int cyc);
    cyc = 0;
    while (busy !== lvl && cyc < 5000) begin tick(1); cyc++; end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, s0, s1;
    logic       oe;
    int         cyc;

    tick(3);
    // R12 reset state
    chk("R12 busy", {7'd0, busy}, 8'h00);
    chk("R12 dq_oe", {7'd0, dq_oe}, 8'h00);
    rst = 1'b0;
    tick(2);

    // R2: write with output enable low loads nothing
    @(negedge clk);
    addr = 17'h00100; din = 8'h33; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    tick(3);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    tick(TO + 20);
    chk("R2 oe-low write ignored", {7'd0, busy}, 8'h00);

    // table walk: load page 2
    for (int i = 0; i < 128; i++) exp_pg[i] = 8'hFF;
    for (int i = 0; i < NV; i++) begin
      wr_we({10'd2, LOADS[i][14:8]}, LOADS[i][7:0]);
      exp_pg[LOADS[i][14:8]] = LOADS[i][7:0];
      tick(TO / 2);
      chk("R6 still loading", {7'd0, busy}, 8'h00);
    end
    wait_busy(1'b1, cyc);
    chk("R7 timeout window", {7'd0, (cyc >= TO - 12 - 2 && cyc <= TO - 12 + 3)}, 8'h01);

    // status reads during programming
    rd({10'd2, 7'd0}, s0, oe);
    chk("R9 dq7 inverse", {7'd0, s0[7]}, {7'd0, ~LOADS[NV-1][7]});
    chk("R1 dq_oe on read", {7'd0, oe}, 8'h01);
    rd({10'd2, 7'd0}, s1, oe);
    chk("R10 dq6 toggles", {7'd0, s1[6]}, {7'd0, ~s0[6]});
    // R11: load while busy is ignored
    wr_we({10'd2, 7'd100}, 8'h55);
    rd({10'd2, 7'd0}, d, oe);
    chk("R11 status unchanged", {7'd0, d[7]}, {7'd0, ~LOADS[NV-1][7]});
    chk("R10 dq6 toggles again", {7'd0, d[6]}, {7'd0, s0[6]});
    wait_busy(1'b0, cyc);
    tick(TO + 20);
    chk("R11 no new load phase", {7'd0, busy}, 8'h00);

    // readback (R3 offsets, R4 overwrite, R8 fill)
    for (int i = 0; i < NV; i++) begin
      rd({10'd2, LOADS[i][14:8]}, d, oe);
      chk("R3 R4 loaded byte", d, exp_pg[LOADS[i][14:8]]);
    end
    rd({10'd2, 7'd100}, d, oe);
    chk("R8 R11 unloaded byte is FF", d, 8'hFF);
    rd({10'd2, 7'd126}, d, oe);
    chk("R8 unloaded byte is FF", d, 8'hFF);
    rd({10'd2, 7'd9}, s0, oe);
    rd({10'd2, 7'd9}, s1, oe);
    chk("R10 dq6 stable after completion", {7'd0, s1[6]}, {7'd0, s0[6]});

    // R1: deselect forms
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; tick(2);
    chk("R1 ce high hiz", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1; tick(2);
    chk("R1 oe high hiz", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b1; tick(1);

    // R5: last byte's page selects target; chip-select controlled loads
    wr_ce({10'd4, 7'd1}, 8'h11);
    wr_ce({10'd6, 7'd2}, 8'h22);
    wait_busy(1'b1, cyc);
    wait_busy(1'b0, cyc);
    chk("R7 prog length", cyc[7:0], PROG[7:0]);
    rd({10'd6, 7'd1}, d, oe);
    chk("R5 byte lands in last page", d, 8'h11);
    rd({10'd6, 7'd2}, d, oe);
    chk("R5 R2 last byte", d, 8'h22);
    rd({10'd6, 7'd0}, d, oe);
    chk("R8 fresh phase fill", d, 8'hFF);
    rd({10'd2, 7'd1}, d, oe);
    chk("R5 other page untouched", d, 8'hA5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule